// File: doc/BRIEF.md
# Scanning ADC Sample Sequencer

This block sits between a register bus and a successive-approximation conversion core. Software programs a list of up to eight input channels, a scan length, and a pause between conversions. It then writes a start command. The sequencer walks the list and hands each channel number to the converter over a request/done handshake. Each result is stored in a 32-entry FIFO, tagged with the channel it came from.

A scan runs either once over the list or repeatedly until software asks it to stop. A stop request takes effect at a conversion boundary: any conversion in flight completes and is stored first. Software learns the state of the engine by polling busy flags and FIFO fill level in the status word. It can also use a level interrupt that rises once the FIFO holds at least a programmed number of entries. Each read of the FIFO word removes one entry.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control/status word (word address 0) reads 0x0400_0000: only the empty flag (bit 26) is set. The conversion request and the interrupt are low.
- R2: A write to word 0 with bit 2 (start) and bit 0 (enable) both set starts a scan. Sample-busy (bit 28) reads 1 on the very next cycle. A start with bit 0 clear is ignored, and so is a start while a scan is running.
- R3: The list register (word 1) holds channel entry n at bits 3n+2:3n and the last index to scan at bits 26:24. The channels are converted in index order from 0. In single mode (bit 1 of word 0 clear) one pass is made and the engine returns to idle.
- R4: A read of word 3 returns the oldest FIFO entry, with the sample in bits 11:0 and the channel tag in bits 14:12, and removes it. Entries come out in the order they were converted.
- R5: The delay register (word 2, bits 7:0) sets the pause between conversions. The conversion request stays low for exactly count+1 clock cycles between two consecutive conversions.
- R6: In continuous mode (bit 1 of word 0 set) the scan wraps back to index 0 without end. A write with bit 14 set ends the scan at the next conversion boundary: no further request is issued, and all busy flags (bits 30:28) read 0.
- R7: The FIFO holds 32 entries. Its fill level appears in bits 25:21 (modulo 32), with full at bit 27 and empty at bit 26. A result that arrives while the FIFO is full is discarded, and the stored entries stay unchanged.
- R8: A read of word 3 while the FIFO is empty returns 0 and leaves the fill level at 0.
- R9: The interrupt output is high exactly while the interrupt enable (bit 3 of word 0) is set and the fill level is at least the threshold in bits 8:4 of word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO at word 3) |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| conv_req | output | 1 | Conversion request, held until done |
| conv_chan | output | 3 | Channel to convert |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_data | input | 12 | Conversion result, valid with conv_done |
| fifo_irq | output | 1 | FIFO level interrupt |

## Verification
The scan is driven with a three-entry list in non-sequential channel order, a five-entry list in ascending order, and single-entry lists in continuous mode. Together these separate a correct list walk from one that ignores the last-index field, loses wrap-around, or mixes up tags. Delay values of 0 and 5 show whether the pause is off by one cycle. A continuous run held past 32 results shows whether overflow discards new data or overwrites old entries. Starts issued with enable clear and during a running scan, a stop request, and reads of an empty FIFO each check that the block reacts only when it should.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the scanning sample sequencer: register word
// addresses, bit positions within the register words, engine states.
// Assumes a 32-bit register word and 2-bit word addressing.
package adc_scan_pkg;
    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_LIST  = 2'd1;
    localparam logic [1:0] ADDR_DELAY = 2'd2;
    localparam logic [1:0] ADDR_FIFO  = 2'd3;

    localparam int CTL_EN      = 0;
    localparam int CTL_CONT    = 1;
    localparam int CTL_START   = 2;
    localparam int CTL_IRQ_EN  = 3;
    localparam int CTL_THR_LSB = 4;
    localparam int CTL_STOP    = 14;
    localparam int ST_LVL_LSB  = 21;
    localparam int ST_EMPTY    = 26;
    localparam int ST_FULL     = 27;
    localparam int ST_SBUSY    = 28;
    localparam int ST_ABUSY    = 29;
    localparam int ST_DBUSY    = 30;
    localparam int LIST_MAX_LSB = 24;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_CONV = 2'd1,
        ENG_WAIT = 2'd2
    } eng_state_t;
endpackage

// File: rtl/adc_scan_fifo.sv
`timescale 1ns/1ps
// Result FIFO. A push while full is dropped. A pop while empty does
// nothing, and the head then reads as zero. Assumes DEPTH is a power of two
// so the pointers wrap naturally.
module adc_scan_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [WIDTH-1:0]         wdata,
    input  logic                     pop,
    output logic [WIDTH-1:0]         rdata,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     full,
    output logic                     empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             push_ok, pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rptr];

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wdata;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/adc_scan_engine.sv
`timescale 1ns/1ps
// Scan engine: walks the channel list, handshakes with the converter,
// emits one tagged result per conversion and times the pause between
// conversions. Start is honoured only when idle. A stop is latched and
// taken at the next conversion boundary or during the pause.
module adc_scan_engine
    import adc_scan_pkg::*;
#(
    parameter int LIST_LEN = 8,
    parameter int CHAN_W   = 3,
    parameter int SAMPLE_W = 12,
    parameter int DLY_W    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         stop,
    input  logic                         cont,
    input  logic [LIST_LEN*CHAN_W-1:0]   list,
    input  logic [$clog2(LIST_LEN)-1:0]  max_idx,
    input  logic [DLY_W-1:0]             dly,
    output logic                         conv_req,
    output logic [CHAN_W-1:0]            conv_chan,
    input  logic                         conv_done,
    input  logic [SAMPLE_W-1:0]          conv_data,
    output logic                         push,
    output logic [CHAN_W+SAMPLE_W-1:0]   push_word,
    output logic                         busy
);
    localparam int IDX_W = $clog2(LIST_LEN);

    eng_state_t       state;
    logic [IDX_W-1:0] idx;
    logic [DLY_W-1:0] dcnt;
    logic             stop_pend, halt, last;

    assign halt      = stop_pend || stop;
    assign last      = (idx == max_idx);
    assign busy      = (state != ENG_IDLE);
    assign conv_req  = (state == ENG_CONV);
    assign conv_chan = list[int'(idx)*CHAN_W +: CHAN_W];
    assign push      = conv_req && conv_done;
    assign push_word = {conv_chan, conv_data};

    // Scan sequencing, pause counting and stop handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ENG_IDLE;
            idx       <= '0;
            dcnt      <= '0;
            stop_pend <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    stop_pend <= 1'b0;
                    if (start) begin
                        state <= ENG_CONV;
                        idx   <= '0;
                    end
                end
                ENG_CONV: begin
                    stop_pend <= halt;
                    if (conv_done) begin
                        if (halt || (last && !cont)) begin
                            state     <= ENG_IDLE;
                            stop_pend <= 1'b0;
                        end else begin
                            state <= ENG_WAIT;
                            dcnt  <= '0;
                            idx   <= last ? '0 : IDX_W'(idx + 1'b1);
                        end
                    end
                end
                ENG_WAIT: begin
                    if (halt) begin
                        state     <= ENG_IDLE;
                        stop_pend <= 1'b0;
                    end else if (dcnt == dly) begin
                        state <= ENG_CONV;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
// Top of the sequencer: register file and read mux, start/stop decode,
// FIFO level interrupt, and the engine and FIFO instances. Assumes
// the fixed 32-bit register layout from adc_scan_pkg. The averaging and
// delta busy flags read as zero because no such stage is present.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int LIST_LEN   = 8,
    parameter int CHAN_W     = 3,
    parameter int SAMPLE_W   = 12,
    parameter int DLY_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [1:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                conv_req,
    output logic [CHAN_W-1:0]   conv_chan,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] conv_data,
    output logic                fifo_irq
);
    localparam int LVL_W  = $clog2(FIFO_DEPTH);
    localparam int CNT_W  = LVL_W + 1;
    localparam int IDX_W  = $clog2(LIST_LEN);
    localparam int WORD_W = CHAN_W + SAMPLE_W;

    logic                       en_q, cont_q, irq_en_q;
    logic [LVL_W-1:0]           thr_q;
    logic [LIST_LEN*CHAN_W-1:0] list_q;
    logic [IDX_W-1:0]           max_q;
    logic [DLY_W-1:0]           dly_q;
    logic                       wr_ctrl, start, stop, pop, push, eng_busy;
    logic [WORD_W-1:0]          push_word, head;
    logic [CNT_W-1:0]           fifo_cnt;
    logic                       fifo_full, fifo_empty;
    logic                       unused_wdata;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign start   = wr_ctrl && bus_wdata[CTL_START] && bus_wdata[CTL_EN];
    assign stop    = wr_ctrl && bus_wdata[CTL_STOP];
    assign pop     = bus_rd && (bus_addr == ADDR_FIFO);
    assign fifo_irq = irq_en_q && ({1'b0, thr_q} <= fifo_cnt);
    assign unused_wdata = ^bus_wdata;

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            cont_q   <= 1'b0;
            irq_en_q <= 1'b0;
            thr_q    <= '0;
            list_q   <= '0;
            max_q    <= '0;
            dly_q    <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_CTRL: begin
                    en_q     <= bus_wdata[CTL_EN];
                    cont_q   <= bus_wdata[CTL_CONT];
                    irq_en_q <= bus_wdata[CTL_IRQ_EN];
                    thr_q    <= bus_wdata[CTL_THR_LSB +: LVL_W];
                end
                ADDR_LIST: begin
                    list_q <= bus_wdata[0 +: LIST_LEN*CHAN_W];
                    max_q  <= bus_wdata[LIST_MAX_LSB +: IDX_W];
                end
                ADDR_DELAY: dly_q <= bus_wdata[0 +: DLY_W];
                default: ;
            endcase
        end
    end

    // Read data mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTL_EN]                 = en_q;
                bus_rdata[CTL_CONT]               = cont_q;
                bus_rdata[CTL_IRQ_EN]             = irq_en_q;
                bus_rdata[CTL_THR_LSB +: LVL_W]   = thr_q;
                bus_rdata[ST_LVL_LSB +: LVL_W]    = fifo_cnt[LVL_W-1:0];
                bus_rdata[ST_EMPTY]               = fifo_empty;
                bus_rdata[ST_FULL]                = fifo_full;
                bus_rdata[ST_SBUSY]               = eng_busy;
                bus_rdata[ST_ABUSY]               = 1'b0;
                bus_rdata[ST_DBUSY]               = 1'b0;
            end
            ADDR_LIST: begin
                bus_rdata[0 +: LIST_LEN*CHAN_W]   = list_q;
                bus_rdata[LIST_MAX_LSB +: IDX_W]  = max_q;
            end
            ADDR_DELAY: bus_rdata[0 +: DLY_W]     = dly_q;
            default:    bus_rdata[0 +: WORD_W]    = head;
        endcase
    end

    adc_scan_engine #(
        .LIST_LEN (LIST_LEN),
        .CHAN_W   (CHAN_W),
        .SAMPLE_W (SAMPLE_W),
        .DLY_W    (DLY_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .cont      (cont_q),
        .list      (list_q),
        .max_idx   (max_q),
        .dly       (dly_q),
        .conv_req  (conv_req),
        .conv_chan (conv_chan),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .push      (push),
        .push_word (push_word),
        .busy      (eng_busy)
    );

    adc_scan_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (WORD_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (push_word),
        .pop   (pop),
        .rdata (head),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );
endmodule

// File: rtl/adc_scan_seq_chk.sv
`timescale 1ns/1ps
// Property checker for adc_scan_seq, attached by bind. Observes the
// engine handshake, the start/stop decode and the FIFO level.
module adc_scan_seq_chk #(
    parameter int FIFO_DEPTH = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start,
    input logic                        stop,
    input logic                        busy,
    input logic                        conv_req,
    input logic                        conv_done,
    input logic                        push,
    input logic                        pop,
    input logic [$clog2(FIFO_DEPTH):0] cnt,
    input logic                        full,
    input logic                        empty
);
    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    req_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> busy);

    // R6
    stop_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && busy && !conv_req) |=> !busy);

    // R6
    stop_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && conv_req && conv_done) |=> !busy);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FIFO_DEPTH));

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(cnt));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (cnt == '0));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_adc_scan_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .busy      (eng_busy),
    .conv_req  (conv_req),
    .conv_done (conv_done),
    .push      (push),
    .pop       (pop),
    .cnt       (fifo_cnt),
    .full      (fifo_full),
    .empty     (fifo_empty)
);

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
// Directed bench for adc_scan_seq with a behavioural converter stub.
module test_adc_scan_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        conv_req;
    logic [2:0]  conv_chan;
    logic        conv_done;
    logic [11:0] conv_data;
    logic        fifo_irq;

    logic [7:0]  samp_no;
    logic [1:0]  lat;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    adc_scan_seq i_adc_scan_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .conv_req  (conv_req),
        .conv_chan (conv_chan),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .fifo_irq  (fifo_irq)
    );

    // Converter stub: answers each request after three cycles with
    // 0xA in the top nibble and a running sample number below.
    always @(posedge clk) begin
        if (!rst_n) begin
            conv_done <= 1'b0;
            conv_data <= 12'd0;
            samp_no   <= 8'd0;
            lat       <= 2'd0;
        end else if (conv_done) begin
            conv_done <= 1'b0;
        end else if (conv_req) begin
            if (lat == 2'd2) begin
                conv_done <= 1'b1;
                conv_data <= {4'hA, samp_no};
                samp_no   <= samp_no + 8'd1;
                lat       <= 2'd0;
            end else begin
                lat <= lat + 2'd1;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic wait_idle;
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd0, v);
            if (v[30:28] == 3'b000) break;
        end
    endtask

    task automatic drain;
        logic [31:0] v, w;
        for (int i = 0; i < 40; i++) begin
            rd(2'd0, v);
            if (v[26]) break;
            rd(2'd3, w);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v);
        chk("R1 status after reset", v, 32'h0400_0000);
        chk("R1 conv_req after reset", 32'(conv_req), 32'd0);
        chk("R1 irq after reset", 32'(fifo_irq), 32'd0);
    endtask

    task automatic t_single_scan;
        logic [31:0] v, w;
        logic [7:0]  base;
        logic [2:0]  chans [3];
        chans[0] = 3'd5; chans[1] = 3'd2; chans[2] = 3'd7;
        wr(2'd1, 32'd5 | (32'd2 << 3) | (32'd7 << 6) | (32'd2 << 24));
        wr(2'd2, 32'd3);
        base = samp_no;
        wr(2'd0, 32'h5);
        rd(2'd0, v);
        chk("R2 sample-busy right after start", 32'(v[28]), 32'd1);
        wr(2'd0, 32'h5);
        wait_idle;
        rd(2'd0, v);
        chk("R3 single pass level", 32'(v[25:21]), 32'd3);
        chk("R2 repeated start ignored, level", 32'(v[26]), 32'd0);
        for (int k = 0; k < 3; k++) begin
            rd(2'd3, w);
            chk($sformatf("R3 tag of entry %0d", k), 32'(w[14:12]), 32'(chans[k]));
            chk($sformatf("R4 sample of entry %0d", k), 32'(w[11:0]), 32'({4'hA, 8'(base + 8'(k))}));
        end
        rd(2'd3, w);
        chk("R8 empty read value", w, 32'd0);
        rd(2'd0, v);
        chk("R8 empty read level", 32'(v[25:21]), 32'd0);
        chk("R8 empty flag", 32'(v[26]), 32'd1);
    endtask

    task automatic t_no_enable;
        logic [31:0] v;
        wr(2'd0, 32'h4);
        repeat (10) @(negedge clk);
        rd(2'd0, v);
        chk("R2 start without enable busy", 32'(v[30:28]), 32'd0);
        chk("R2 start without enable level", 32'(v[25:21]), 32'd0);
    endtask

    task automatic t_gap(input int d);
        int g = 0;
        wr(2'd1, 32'd1 | (32'd1 << 3) | (32'd1 << 24));
        wr(2'd2, 32'(d));
        wr(2'd0, 32'h5);
        while (!conv_req) @(negedge clk);
        while (conv_req) @(negedge clk);
        while (!conv_req) begin
            g++;
            @(negedge clk);
        end
        chk($sformatf("R5 request gap for delay %0d", d), 32'(g), 32'(d + 1));
        wait_idle;
        drain;
    endtask

    task automatic t_cont_stop;
        logic [31:0] v, w;
        logic [4:0]  c;
        wr(2'd1, 32'd3);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h7);
        repeat (40) @(negedge clk);
        wr(2'd0, 32'h4003);
        wait_idle;
        rd(2'd0, v);
        c = v[25:21];
        chk("R6 continuous mode wrapped", 32'(c >= 5'd2), 32'd1);
        chk("R6 busy flags clear after stop", 32'(v[30:28]), 32'd0);
        repeat (20) @(negedge clk);
        chk("R6 no request after stop", 32'(conv_req), 32'd0);
        rd(2'd0, v);
        chk("R6 level frozen after stop", 32'(v[25:21]), 32'(c));
        for (int k = 0; k < int'(c); k++) begin
            rd(2'd3, w);
            chk("R6 wrapped tag", 32'(w[14:12]), 32'd3);
        end
    endtask

    task automatic t_full;
        logic [31:0] v, w;
        logic [7:0]  base;
        wr(2'd1, 32'd6);
        wr(2'd2, 32'd0);
        base = samp_no;
        wr(2'd0, 32'h7);
        for (int i = 0; i < 600; i++) begin
            rd(2'd0, v);
            if (v[27]) break;
        end
        repeat (30) @(negedge clk);
        wr(2'd0, 32'h4003);
        wait_idle;
        rd(2'd0, v);
        chk("R7 full flag", 32'(v[27]), 32'd1);
        chk("R7 level field wraps at 32", 32'(v[25:21]), 32'd0);
        chk("R7 not empty when full", 32'(v[26]), 32'd0);
        for (int k = 0; k < 32; k++) begin
            rd(2'd3, w);
            chk($sformatf("R7 kept entry %0d", k), 32'(w[14:0]), 32'({3'd6, 4'hA, 8'(base + 8'(k))}));
        end
        rd(2'd0, v);
        chk("R7 empty after 32 pops", 32'(v[27:26]), 32'd1);
    endtask

    task automatic t_irq;
        logic [31:0] w;
        wr(2'd1, 32'd0 | (32'd1 << 3) | (32'd2 << 6) | (32'd3 << 9) | (32'd4 << 12) | (32'd4 << 24));
        wr(2'd2, 32'd1);
        wr(2'd0, 32'h1 | 32'h4 | 32'h8 | (32'd4 << 4));
        wait_idle;
        @(negedge clk);
        chk("R9 irq at level 5 threshold 4", 32'(fifo_irq), 32'd1);
        for (int k = 0; k < 2; k++) begin
            rd(2'd3, w);
            chk("R3 ascending list tag", 32'(w[14:12]), 32'(k));
        end
        chk("R9 irq low at level 3 threshold 4", 32'(fifo_irq), 32'd0);
        wr(2'd0, 32'h1 | (32'd2 << 4));
        chk("R9 irq low when disabled", 32'(fifo_irq), 32'd0);
        wr(2'd0, 32'h1 | 32'h8 | (32'd2 << 4));
        chk("R9 irq at level 3 threshold 2", 32'(fifo_irq), 32'd1);
        for (int k = 2; k < 5; k++) begin
            rd(2'd3, w);
            chk("R3 ascending list tag", 32'(w[14:12]), 32'(k));
        end
        chk("R9 irq low when drained", 32'(fifo_irq), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R6 watchdog: run hung actual=running expected=finished");
        finish_run;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_single_scan;
        t_no_enable;
        t_gap(5);
        t_gap(0);
        t_cont_stop;
        t_full;
        t_irq;
        finish_run;
    end
endmodule